// File: doc/BRIEF.md
# 2D Rectangle Copy and Fill Engine

This block is a small 2D drawing accelerator. Configuration registers outside the block set a pixel format, the base addresses and pitches, a raster-op code, a brush colour and two palette colours. A one-cycle start strobe then launches a single rectangle operation. The operation is either a copy from one memory region to another or a fill with a solid colour. The block checks the format, the op code and the memory bounds. If all pass, it walks the rectangle row by row and pixel by pixel through a 32-bit word memory port that uses a valid/ready handshake.

When the operation ends, the block pulses done. At that moment the outcome flags are valid. On a successful operation the destination coordinates it keeps are advanced, so that back-to-back operations can tile across the screen. Those coordinates are loaded from outside while the block is idle.

Top module: `blit2d_engine`

## Requirements
- R1: `fmt_code` sets the pixel size: 2 is 1 byte, 3 and 4 are 2 bytes, 5 is 3 bytes and 6 is 4 bytes. Any other code raises `fmt_err` with done. There is then no memory traffic and the coordinates do not change.
- R2: With `own_sel` high, the source uses `src_off`/`src_pitch` and the destination uses `dst_off`/`dst_pitch`. With `own_sel` low, both use `dflt_off`/`dflt_pitch`. Pitches are in bytes.
- R3: With `variant_en` high, `disp_start[26:0]` is added to both bases. Each selected pitch then counts pixels and is multiplied by the pixel size in bytes.
- R4: The block raises `oob_rej` with no memory traffic when either test reaches `MEM_BYTES`: the destination base itself, or base + dst_x + (dst_y + rect_h) × pitch. A copy applies the same test to the source, using src_x, src_y and rect_h. The tests run in this order: format, destination bounds, op code, source bounds.
- R5: The op code is `mix[23:16]`. 0xCC is copy, 0xF0 is pattern fill, 0x00 is black fill and 0xFF is white fill. Any other value raises `rop_err` with no memory traffic.
- R6: A pattern fill uses `brush_fg` with its four bytes in reverse order. A pixel takes the low bytes of the fill word, byte 0 at the lowest address.
- R7: A black fill uses the word {pal0_rgb, 8'hFF}. A white fill uses {pal1_rgb, 8'hFF}.
- R8: A copy places the pixel found at byte address src_base + (src_y+r)×pitch + (src_x+c)×size at the matching destination address dst_base + (dst_y+r)×pitch + (dst_x+c)×size. Memory is little-endian.
- R9: After a successful copy, dst_x grows by rect_w and dst_y by rect_h. After a successful fill, only dst_y grows by rect_h. The coordinates hold while busy. `xy_load` loads them only while idle.
- R10: After reset, busy, done and mem_req are low and the coordinates are 0. Busy rises on the cycle after an accepted start. Done is high for one cycle, with busy low in that cycle. A start while busy is ignored.
- R11: A zero rect_w or rect_h that passes all checks ends with done and no memory traffic. The R9 increments still apply.
- R12: Pixels go out in raster order. Each pixel is written with byte enables covering only its own bytes. A pixel that crosses a word boundary takes two write beats: the lower word first, then the upper word.
- R13: A beat completes on a cycle where mem_req and mem_ready are both high. Read data is taken in that cycle. Address, write enable, byte enables and write data hold steady while the beat stalls. Write data in disabled byte lanes carry no meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one operation when idle |
| fmt_code | input | 4 | Pixel format code |
| own_sel | input | 1 | Selects the dedicated offsets and pitches over the shared ones |
| variant_en | input | 1 | Display-start offset and pixel-unit pitch mode |
| disp_start | input | 32 | Display start offset (low 27 bits used) |
| src_off | input | OW | Source base, byte address |
| src_pitch | input | PW | Source pitch |
| dst_off | input | OW | Destination base, byte address |
| dst_pitch | input | PW | Destination pitch |
| dflt_off | input | OW | Shared base |
| dflt_pitch | input | PW | Shared pitch |
| mix | input | 32 | Mix register; op code in bits 23:16 |
| brush_fg | input | 32 | Brush foreground colour |
| pal0_rgb | input | 24 | Palette entry 0 colour |
| pal1_rgb | input | 24 | Palette entry 1 colour |
| src_x | input | CW | Source left column |
| src_y | input | CW | Source top row |
| rect_w | input | CW | Rectangle width in pixels |
| rect_h | input | CW | Rectangle height in rows |
| xy_load | input | 1 | Loads the destination coordinates when idle |
| xy_load_x | input | CW | Value loaded into dst_x |
| xy_load_y | input | CW | Value loaded into dst_y |
| mem_ready | input | 1 | Memory accepts the current beat |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | MAW | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Unknown pixel format |
| rop_err | output | 1 | Unsupported op code |
| oob_rej | output | 1 | Rectangle outside memory |
| dst_x | output | CW | Destination column |
| dst_y | output | CW | Destination row |

## Verification
The assertions assume that every configuration input stays constant from the start strobe until done, since the engine rereads them on every beat. The bench changes them only between operations, while the block is idle. They also assume that the source and destination regions of a copy do not overlap; the bench keeps them disjoint. The assertions assume nothing about mem_ready. The bench drives it in a repeating stall pattern, so that reads, single writes and split writes all see held beats.

// File: rtl/blit2d_engine.sv
module blit2d_engine #(
  parameter int CW = 12,
  parameter int PW = 16,
  parameter int OW = 24,
  parameter int MEM_BYTES = 4096,
  localparam int MAW = $clog2(MEM_BYTES) - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     fmt_code,
  input  logic           own_sel,
  input  logic           variant_en,
  input  logic [31:0]    disp_start,
  input  logic [OW-1:0]  src_off,
  input  logic [PW-1:0]  src_pitch,
  input  logic [OW-1:0]  dst_off,
  input  logic [PW-1:0]  dst_pitch,
  input  logic [OW-1:0]  dflt_off,
  input  logic [PW-1:0]  dflt_pitch,
  input  logic [31:0]    mix,
  input  logic [31:0]    brush_fg,
  input  logic [23:0]    pal0_rgb,
  input  logic [23:0]    pal1_rgb,
  input  logic [CW-1:0]  src_x,
  input  logic [CW-1:0]  src_y,
  input  logic [CW-1:0]  rect_w,
  input  logic [CW-1:0]  rect_h,
  input  logic           xy_load,
  input  logic [CW-1:0]  xy_load_x,
  input  logic [CW-1:0]  xy_load_y,
  input  logic           mem_ready,
  input  logic [31:0]    mem_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [3:0]     mem_be,
  output logic [31:0]    mem_wdata,
  output logic           busy,
  output logic           done,
  output logic           fmt_err,
  output logic           rop_err,
  output logic           oob_rej,
  output logic [CW-1:0]  dst_x,
  output logic [CW-1:0]  dst_y
);
  localparam int XW = (OW > 27 ? OW : 27) + PW + CW + 4;
  localparam logic [7:0] ROP_SRC = 8'hCC;
  localparam logic [7:0] ROP_PAT = 8'hF0;
  localparam logic [7:0] ROP_BLK = 8'h00;
  localparam logic [7:0] ROP_WHT = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD0, S_RD1, S_WR0, S_WR1} st_t;
  st_t st;

  logic [2:0] bpb;
  always_comb begin
    case (fmt_code)
      4'd2:       bpb = 3'd1;
      4'd3, 4'd4: bpb = 3'd2;
      4'd5:       bpb = 3'd3;
      4'd6:       bpb = 3'd4;
      default:    bpb = 3'd0;
    endcase
  end

  wire [7:0] rop     = mix[23:16];
  wire       is_copy = rop == ROP_SRC;
  wire       rop_ok  = is_copy | (rop == ROP_PAT) | (rop == ROP_BLK) | (rop == ROP_WHT);

  logic [31:0] fill_word;
  always_comb begin
    case (rop)
      ROP_PAT: fill_word = {brush_fg[7:0], brush_fg[15:8], brush_fg[23:16], brush_fg[31:24]};
      ROP_BLK: fill_word = {pal0_rgb, 8'hFF};
      ROP_WHT: fill_word = {pal1_rgb, 8'hFF};
      default: fill_word = 32'd0;
    endcase
  end

  wire [XW-1:0] scale   = variant_en ? XW'(bpb) : XW'(1);
  wire [XW-1:0] adj     = variant_en ? XW'(disp_start[26:0]) : '0;
  wire [XW-1:0] s_base  = (own_sel ? XW'(src_off) : XW'(dflt_off)) + adj;
  wire [XW-1:0] d_base  = (own_sel ? XW'(dst_off) : XW'(dflt_off)) + adj;
  wire [XW-1:0] s_pitch = (own_sel ? XW'(src_pitch) : XW'(dflt_pitch)) * scale;
  wire [XW-1:0] d_pitch = (own_sel ? XW'(dst_pitch) : XW'(dflt_pitch)) * scale;
  wire [XW-1:0] lim     = XW'(MEM_BYTES);

  wire [XW-1:0] d_reach = d_base + XW'(dst_x) + (XW'(dst_y) + XW'(rect_h)) * d_pitch;
  wire [XW-1:0] s_reach = s_base + XW'(src_x) + (XW'(src_y) + XW'(rect_h)) * s_pitch;
  wire d_bad = (d_base >= lim) || (d_reach >= lim);
  wire s_bad = (s_base >= lim) || (s_reach >= lim);

  logic [CW-1:0] px, py;
  logic [31:0]   rd0, rd1;

  wire [XW-1:0] d_addr = d_base + (XW'(dst_y) + XW'(py)) * d_pitch + (XW'(dst_x) + XW'(px)) * XW'(bpb);
  wire [XW-1:0] s_addr = s_base + (XW'(src_y) + XW'(py)) * s_pitch + (XW'(src_x) + XW'(px)) * XW'(bpb);
  wire [1:0]     d_off  = d_addr[1:0];
  wire [1:0]     s_off  = s_addr[1:0];
  wire [MAW-1:0] d_word = d_addr[MAW+1:2];
  wire [MAW-1:0] s_word = s_addr[MAW+1:2];
  wire           s_two  = (3'(s_off) + bpb) > 3'd4;

  wire [3:0]  pmask  = 4'((5'd1 << bpb) - 5'd1);
  wire [63:0] s_pair = {rd1, rd0} >> {s_off, 3'b000};
  wire [31:0] pix    = is_copy ? s_pair[31:0] : fill_word;
  wire [63:0] w_pair = {32'd0, pix} << {d_off, 3'b000};
  wire [7:0]  b_pair = {4'd0, pmask} << d_off;

  wire unused_bits = ^{s_addr[XW-1:MAW+2], d_addr[XW-1:MAW+2], s_pair[63:32],
                       mix[31:24], mix[15:0], disp_start[31:27]};

  wire last_px  = px == rect_w - CW'(1);
  wire last_py  = py == rect_h - CW'(1);
  wire adv      = mem_ready && (((st == S_WR0) && (b_pair[7:4] == 4'd0)) || (st == S_WR1));
  wire chk_pass = (bpb != 3'd0) && !d_bad && rop_ok && !(is_copy && s_bad);
  wire empty    = (rect_w == '0) || (rect_h == '0);
  wire fin      = (adv && last_px && last_py) || ((st == S_CHK) && chk_pass && empty);

  assign busy      = st != S_IDLE;
  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WR0) || (st == S_WR1);
  assign mem_we    = (st == S_WR0) || (st == S_WR1);
  assign mem_addr  = (st == S_RD0) ? s_word :
                     (st == S_RD1) ? s_word + MAW'(1) :
                     (st == S_WR1) ? d_word + MAW'(1) : d_word;
  assign mem_be    = (st == S_WR0) ? b_pair[3:0] : (st == S_WR1) ? b_pair[7:4] : 4'hF;
  assign mem_wdata = (st == S_WR1) ? w_pair[63:32] : w_pair[31:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      fmt_err <= 1'b0;
      rop_err <= 1'b0;
      oob_rej <= 1'b0;
      px      <= '0;
      py      <= '0;
      rd0     <= '0;
      rd1     <= '0;
      dst_x   <= '0;
      dst_y   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st      <= S_CHK;
            fmt_err <= 1'b0;
            rop_err <= 1'b0;
            oob_rej <= 1'b0;
            px      <= '0;
            py      <= '0;
          end else if (xy_load) begin
            dst_x <= xy_load_x;
            dst_y <= xy_load_y;
          end
        end
        S_CHK: begin
          if (bpb == 3'd0) begin
            fmt_err <= 1'b1;
            st      <= S_IDLE;
            done    <= 1'b1;
          end else if (d_bad) begin
            oob_rej <= 1'b1;
            st      <= S_IDLE;
            done    <= 1'b1;
          end else if (!rop_ok) begin
            rop_err <= 1'b1;
            st      <= S_IDLE;
            done    <= 1'b1;
          end else if (is_copy && s_bad) begin
            oob_rej <= 1'b1;
            st      <= S_IDLE;
            done    <= 1'b1;
          end else if (empty) begin
            st <= S_IDLE;
          end else begin
            st <= is_copy ? S_RD0 : S_WR0;
          end
        end
        S_RD0: if (mem_ready) begin
          rd0 <= mem_rdata;
          st  <= s_two ? S_RD1 : S_WR0;
        end
        S_RD1: if (mem_ready) begin
          rd1 <= mem_rdata;
          st  <= S_WR0;
        end
        S_WR0: if (mem_ready && (b_pair[7:4] != 4'd0)) st <= S_WR1;
        default: ;
      endcase
      if (adv) begin
        if (!last_px) px <= px + CW'(1);
        else begin
          px <= '0;
          if (!last_py) py <= py + CW'(1);
        end
        st <= (last_px && last_py) ? S_IDLE : (is_copy ? S_RD0 : S_WR0);
      end
      if (fin) begin
        done  <= 1'b1;
        dst_y <= dst_y + rect_h;
        if (is_copy) dst_x <= dst_x + rect_w;
      end
    end
  end
endmodule

// File: rtl/blit2d_engine_chk.sv
module blit2d_engine_chk #(
  parameter int CW  = 12,
  parameter int MAW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ready,
  input logic [MAW-1:0] mem_addr,
  input logic [3:0]     mem_be,
  input logic [31:0]    mem_wdata,
  input logic           fmt_err,
  input logic           rop_err,
  input logic           oob_rej,
  input logic [CW-1:0]  dst_x,
  input logic [CW-1:0]  dst_y
);
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R10
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($countones({fmt_err, rop_err, oob_rej}) <= 1)); // R1
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R13
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata))); // R13
  AST_BE_LIVE: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> (mem_be != 4'd0)); // R12
  AST_NO_TRAFFIC_REJ: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !(fmt_err || rop_err || oob_rej)); // R4
  AST_COORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (done || ($stable(dst_x) && $stable(dst_y)))); // R9
endmodule

bind blit2d_engine blit2d_engine_chk #(.CW(CW), .MAW(MAW)) u_chk (.*);

// File: tb/blit2d_engine_tb.sv
module blit2d_engine_tb;
  localparam int CW = 12;
  localparam int PW = 16;
  localparam int OW = 24;
  localparam int MEM_BYTES = 4096;
  localparam int MAW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] fmt_code = 4'd6;
  logic own_sel = 1'b0, variant_en = 1'b0;
  logic [31:0] disp_start = '0;
  logic [OW-1:0] src_off = '0, dst_off = '0, dflt_off = '0;
  logic [PW-1:0] src_pitch = '0, dst_pitch = '0, dflt_pitch = '0;
  logic [31:0] mix = '0, brush_fg = '0;
  logic [23:0] pal0_rgb = '0, pal1_rgb = '0;
  logic [CW-1:0] src_x = '0, src_y = '0, rect_w = '0, rect_h = '0;
  logic xy_load = 1'b0;
  logic [CW-1:0] xy_load_x = '0, xy_load_y = '0;
  logic mem_ready;
  logic [31:0] mem_rdata;
  logic mem_req, mem_we, busy, done, fmt_err, rop_err, oob_rej;
  logic [MAW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [CW-1:0] dst_x, dst_y;

  always #2.5 clk = ~clk;

  blit2d_engine #(.CW(CW), .PW(PW), .OW(OW), .MEM_BYTES(MEM_BYTES)) u_dut (.*);

  logic [31:0] mem [0:1023];
  logic [2:0] rcnt = '0;
  always @(posedge clk) rcnt <= rcnt + 3'd1;
  assign mem_ready = (rcnt != 3'd2) && (rcnt != 3'd5);
  assign mem_rdata = mem[mem_addr];

  int checks = 0, errors = 0, traffic = 0;
  string cur_req = "R8";
  logic [45:0] expq [$];
  int unsigned exp_dx = 0, exp_dy = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      traffic++;
      if (mem_we) begin
        logic [45:0] e;
        logic [31:0] m;
        m = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};
        if (expq.size() == 0) chk(cur_req, "unexpected write addr", longint'(mem_addr), -1);
        else begin
          e = expq.pop_front();
          chk(cur_req, "write beat {addr,be,data}", longint'({mem_addr, mem_be, mem_wdata & m}), longint'(e));
        end
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr][8*k +: 8] = mem_wdata[8*k +: 8];
      end
    end
  end

  function automatic int size_of(input logic [3:0] c);
    case (c)
      4'd2: return 1;
      4'd3, 4'd4: return 2;
      4'd5: return 3;
      4'd6: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] rbyte(input int unsigned a);
    return mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  task automatic gen_expected;
    int B;
    int unsigned sb, db, sp, dp, da, sa, w0, a;
    logic [7:0] rp;
    logic [31:0] fw, d0, d1;
    logic [3:0] be0, be1;
    logic [7:0] v [4];
    B = size_of(fmt_code);
    rp = mix[23:16];
    sb = own_sel ? src_off : dflt_off;
    db = own_sel ? dst_off : dflt_off;
    sp = own_sel ? src_pitch : dflt_pitch;
    dp = own_sel ? dst_pitch : dflt_pitch;
    if (variant_en) begin
      sb += disp_start & 32'h07FF_FFFF;
      db += disp_start & 32'h07FF_FFFF;
      sp *= B;
      dp *= B;
    end
    if (rp == 8'hF0) fw = {brush_fg[7:0], brush_fg[15:8], brush_fg[23:16], brush_fg[31:24]};
    else if (rp == 8'h00) fw = {pal0_rgb, 8'hFF};
    else fw = {pal1_rgb, 8'hFF};
    for (int r = 0; r < int'(rect_h); r++) begin
      for (int c = 0; c < int'(rect_w); c++) begin
        da = db + (exp_dy + r) * dp + (exp_dx + c) * B;
        sa = sb + (src_y + r) * sp + (src_x + c) * B;
        for (int k = 0; k < B; k++) v[k] = (rp == 8'hCC) ? rbyte(sa + k) : fw[8*k +: 8];
        w0 = da >> 2;
        be0 = '0; be1 = '0; d0 = '0; d1 = '0;
        for (int k = 0; k < B; k++) begin
          a = da + k;
          if ((a >> 2) == w0) begin be0[a & 3] = 1'b1; d0[8*(a & 3) +: 8] = v[k]; end
          else begin be1[a & 3] = 1'b1; d1[8*(a & 3) +: 8] = v[k]; end
        end
        expq.push_back({w0[MAW-1:0], be0, d0});
        if (be1 != 4'd0) expq.push_back({w0[MAW-1:0] + MAW'(1), be1, d1});
      end
    end
  endtask

  task automatic load_xy(input int x, input int y);
    @(negedge clk);
    xy_load = 1'b1; xy_load_x = CW'(x); xy_load_y = CW'(y);
    @(negedge clk);
    xy_load = 1'b0;
    exp_dx = x; exp_dy = y;
    chk("R9", "loaded dst_x", longint'(dst_x), longint'(x));
    chk("R9", "loaded dst_y", longint'(dst_y), longint'(y));
  endtask

  // code: 0 success, 1 format error, 2 op error, 3 bounds reject
  task automatic go(input string req, input int code, input bit poke);
    cur_req = req;
    if (code == 0) gen_expected();
    traffic = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10", "busy after start", longint'(busy), 1);
    chk("R10", "done after start", longint'(done), 0);
    if (poke) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk("R10", "busy with done", longint'(busy), 0);
    chk(code == 1 ? "R1" : req, "fmt_err", longint'(fmt_err), code == 1);
    chk(code == 2 ? "R5" : req, "rop_err", longint'(rop_err), code == 2);
    chk(code == 3 ? "R4" : req, "oob_rej", longint'(oob_rej), code == 3);
    if (code != 0) chk(req, "memory beats on reject", traffic, 0);
    chk(req, "missing writes", expq.size(), 0);
    expq.delete();
    if (code == 0) begin
      exp_dy = (exp_dy + rect_h) % (1 << CW);
      if (mix[23:16] == 8'hCC) exp_dx = (exp_dx + rect_w) % (1 << CW);
    end
    chk("R9", "dst_x after op", longint'(dst_x), longint'(exp_dx));
    chk("R9", "dst_y after op", longint'(dst_y), longint'(exp_dy));
    @(negedge clk);
    chk("R10", "done width", longint'(done), 0);
    chk("R10", "busy after done", longint'(busy), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i), 8'(i) ^ 8'h3C, ~8'(i)};
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", longint'(busy), 0);
    chk("R10", "reset done", longint'(done), 0);
    chk("R10", "reset mem_req", longint'(mem_req), 0);
    chk("R10", "reset dst_x", longint'(dst_x), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 pattern fill 32bpp, dedicated registers (R2)
    fmt_code = 4'd6; own_sel = 1'b1; dst_off = 24'h100; dst_pitch = 16'd64;
    mix = 32'h00F0_0000; brush_fg = 32'h1122_3344; rect_w = 12'd3; rect_h = 12'd2;
    load_xy(2, 1);
    go("R6", 0, 1'b0);

    // R7 black fill 8bpp through shared registers (R2)
    fmt_code = 4'd2; own_sel = 1'b0; dflt_off = 24'h400; dflt_pitch = 16'd32;
    mix = 32'h0000_0000; pal0_rgb = 24'h123456; rect_w = 12'd5; rect_h = 12'd2;
    load_xy(1, 0);
    go("R7", 0, 1'b0);

    // R12 white fill 24bpp with word-crossing pixels
    fmt_code = 4'd5; own_sel = 1'b1; dst_off = 24'h500; dst_pitch = 16'd48;
    mix = 32'h00FF_0000; pal1_rgb = 24'hABCDEF; rect_w = 12'd3; rect_h = 12'd2;
    load_xy(1, 1);
    go("R12", 0, 1'b0);

    // R1 code 4 is 16bpp
    fmt_code = 4'd4; own_sel = 1'b1; dst_off = 24'h5C0; dst_pitch = 16'd16;
    mix = 32'h00F0_0000; brush_fg = 32'hDEAD_BEEF; rect_w = 12'd3; rect_h = 12'd2;
    load_xy(1, 0);
    go("R1", 0, 1'b0);

    // R8 copy 16bpp
    fmt_code = 4'd3; own_sel = 1'b1; src_off = 24'h000; src_pitch = 16'd32;
    src_x = 12'd1; src_y = 12'd1; dst_off = 24'h600; dst_pitch = 16'd32;
    mix = 32'h00CC_0000; rect_w = 12'd4; rect_h = 12'd3;
    load_xy(0, 0);
    go("R8", 0, 1'b0);

    // R12 copy 24bpp, misaligned source and destination; start while busy (R10)
    fmt_code = 4'd5; src_off = 24'h040; src_pitch = 16'd40; src_x = 12'd2; src_y = 12'd0;
    dst_off = 24'h700; dst_pitch = 16'd40; rect_w = 12'd3; rect_h = 12'd2;
    load_xy(1, 2);
    go("R12", 0, 1'b1);

    // R3 variant fill 16bpp, pitch in pixels, masked display start
    fmt_code = 4'd3; own_sel = 1'b0; variant_en = 1'b1; disp_start = 32'hF800_0200;
    dflt_off = 24'h100; dflt_pitch = 16'd16; mix = 32'h00F0_0000; brush_fg = 32'h0102_0304;
    rect_w = 12'd2; rect_h = 12'd2;
    load_xy(1, 1);
    go("R3", 0, 1'b0);

    // R3 variant copy 32bpp
    fmt_code = 4'd6; own_sel = 1'b1; disp_start = 32'h0800_0080;
    src_off = 24'h000; src_pitch = 16'd4; src_x = 12'd0; src_y = 12'd0;
    dst_off = 24'h800; dst_pitch = 16'd4; mix = 32'h00CC_0000; rect_w = 12'd2; rect_h = 12'd2;
    load_xy(0, 0);
    go("R3", 0, 1'b0);
    variant_en = 1'b0; disp_start = '0;

    // R1 unknown formats
    fmt_code = 4'd7; dst_off = 24'h100; dst_pitch = 16'd64; mix = 32'h00F0_0000;
    rect_w = 12'd2; rect_h = 12'd1;
    load_xy(3, 3);
    go("R1", 1, 1'b0);
    fmt_code = 4'd0;
    go("R1", 1, 1'b0);

    // R5 unsupported op code
    fmt_code = 4'd6; mix = 32'h0066_0000;
    go("R5", 2, 1'b0);

    // R4 destination base at end of memory
    mix = 32'h00F0_0000; dst_off = 24'h1000;
    go("R4", 3, 1'b0);

    // R4 reach exactly at the end, then one row less
    fmt_code = 4'd2; dst_off = 24'hF00; dst_pitch = 16'd64; rect_w = 12'd1; rect_h = 12'd2;
    load_xy(0, 2);
    go("R4", 3, 1'b0);
    rect_h = 12'd1;
    go("R4", 0, 1'b0);

    // R4 copy with source reaching the end
    fmt_code = 4'd6; mix = 32'h00CC_0000; src_off = 24'hFF0; src_pitch = 16'd16;
    src_x = 12'd0; src_y = 12'd0; dst_off = 24'h900; dst_pitch = 16'd16;
    rect_w = 12'd1; rect_h = 12'd1;
    load_xy(0, 0);
    go("R4", 3, 1'b0);

    // R11 zero width fill and zero height copy
    mix = 32'h00F0_0000; rect_w = 12'd0; rect_h = 12'd3;
    load_xy(4, 5);
    go("R11", 0, 1'b0);
    chk("R11", "memory beats for empty fill", traffic, 0);
    mix = 32'h00CC_0000; src_off = 24'h000; rect_w = 12'd2; rect_h = 12'd0;
    go("R11", 0, 1'b0);
    chk("R11", "memory beats for empty copy", traffic, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule